// File: doc/BRIEF.md
# Bus-Attached Port and Interval Timer Peripheral

This peripheral sits on a multiplexed 8-bit address/data bus. The cycle that carries address latch enable (`ale`) captures the low three bits of the address, and a later read or write strobe reaches one of six registers. It holds two 8-bit general ports and one 6-bit general port, each with its own direction bit. It also holds a 14-bit down counter that counts `cnt_tick` pulses and drives `tmr_out`.

Software loads a count and a 2-bit waveform mode into two timer registers. It then writes a command word whose top two bits start the timer, stop it at once, or stop it at the next terminal count. The same command word sets the port directions. A start issued while the counter runs does not disturb the current period. The new count and mode load at the next terminal count. A status read reports whether a terminal count has occurred since the last status read, and the read clears that report.

Top module: `io_timer_port`

## Requirements
- R1: The latched address selects the register: 0 command (write) / status (read), 1 port A, 2 port B, 3 port C, 4 timer low byte, 5 timer high byte. Reads of addresses 6 and 7 return 0.
- R2: The address is taken from `ad_in[2:0]` on a clock edge where `ale` is high. A write happens on each clock edge where `wr_n` is low. `ad_out` carries the selected register and `ad_oe` is high while `rd_n` is low.
- R3: Command bits 0, 1 and 2 set the direction of ports A, B and C (1 = output, which drives `*_oe`). A port read returns the written value when the port is an output, and the input pins when it is an input. Port C reads with bits 7:6 at zero.
- R4: Address 4 holds count bits 7:0. Address 5 holds count bits 13:8 in bits 5:0 and the mode in bits 7:6. A command with bits 7:6 = 11 written while the timer is idle loads this count and mode and starts the timer at once.
- R5: Command bits 7:6 = 01 stops the timer at once and `tmr_out` returns high. Later ticks change nothing, and no terminal count is reported.
- R6: Command bits 7:6 = 10 lets the running timer finish its current period, then stops it at terminal count.
- R7: A start command written while the timer runs leaves the current period untouched. The held count and mode load at the next terminal count, and counting continues.
- R8: Each clock edge with `cnt_tick` high while running moves the counter down by one. The edge where the counter is at 1 is the terminal count, and the counter reloads to the loaded count. Without a tick, the counter and `tmr_out` stay unchanged. Counts are 2 or more.
- R9: Modes 00 and 01 give a square wave: `tmr_out` is high while the counter is above half the count (rounded down), so an odd count gives one extra high step. Mode 00 stops after one period; mode 01 repeats.
- R10: Modes 10 and 11 keep `tmr_out` high except during the final step (counter at 1), when it is low. Mode 10 stops after one period; mode 11 reloads and repeats.
- R11: Status bit 6 is set at every terminal count and clears after a status read. All other status bits read 0.
- R12: While counting, address 4 reads the present counter bits 7:0 and address 5 reads {active mode, counter bits 13:8}.
- R13: Reset halts the timer, drives `tmr_out` high, clears the status flag, makes all ports inputs and clears the port output values. The timer does not run again until a start command is written.

Reset leaves the count and mode values undefined. Only a start command gives them meaning again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address latch enable |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ad_in | input | 8 | Address/data bus in |
| ad_out | output | 8 | Read data |
| ad_oe | output | 1 | Read data valid / bus drive enable |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A output value |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B output value |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 6 | Port C pins in |
| pc_out | output | 6 | Port C output value |
| pc_oe | output | 1 | Port C output enable |
| cnt_tick | input | 1 | Count enable, one count per clock it is high |
| tmr_out | output | 1 | Timer waveform output |

## Verification
The timer is run with an even count in repeating square mode and an odd count in single square mode. This shows whether the half-period split rounds the extra step into the high phase, and whether a single mode stops. The pulse modes are run with a small count, which separates the one low step from the reload behaviour. A start issued mid-period is checked against both the old waveform and the counter read-back before and after the terminal count. A stop-at-terminal-count is checked against a stop-now, which shows the difference between finishing a period and halting in place. Port reads are done with each direction setting, which separates the written value from the pins.

// File: rtl/io_timer_port.sv
module io_timer_port #(
  parameter int DW  = 8,
  parameter int PCW = 6,
  parameter int TW  = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ale,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [DW-1:0]  ad_in,
  output logic [DW-1:0]  ad_out,
  output logic           ad_oe,
  input  logic [DW-1:0]  pa_in,
  output logic [DW-1:0]  pa_out,
  output logic           pa_oe,
  input  logic [DW-1:0]  pb_in,
  output logic [DW-1:0]  pb_out,
  output logic           pb_oe,
  input  logic [PCW-1:0] pc_in,
  output logic [PCW-1:0] pc_out,
  output logic           pc_oe,
  input  logic           cnt_tick,
  output logic           tmr_out
);
  localparam int HW       = TW - DW;
  localparam int DONE_BIT = 6;

  logic [2:0]    addr_q;
  logic [2:0]    dir_q;
  logic [DW-1:0] pa_q, pb_q;
  logic [PCW-1:0] pc_q;
  logic [TW-1:0] ld_cnt, act_len, cur;
  logic [1:0]    ld_mode, act_mode;
  logic          run, stop_tc, start_q, done;

  wire wr_en   = !wr_n;
  wire rd_en   = !rd_n;
  wire wr_cmd  = wr_en && addr_q == 3'd0;
  wire [1:0] op = ad_in[DW-1:DW-2];
  wire tc      = run && cnt_tick && cur == TW'(1);
  wire go_now  = wr_cmd && op == 2'b11 && (!run || tc);
  wire go_tc   = tc && start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      dir_q  <= '0;
      pa_q   <= '0;
      pb_q   <= '0;
      pc_q   <= '0;
    end else begin
      if (ale) addr_q <= ad_in[2:0];
      if (wr_en) begin
        case (addr_q)
          3'd0: dir_q <= ad_in[2:0];
          3'd1: pa_q  <= ad_in;
          3'd2: pb_q  <= ad_in;
          3'd3: pc_q  <= ad_in[PCW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && addr_q == 3'd4) ld_cnt[DW-1:0] <= ad_in;
    if (wr_en && addr_q == 3'd5) begin
      ld_cnt[TW-1:DW] <= ad_in[HW-1:0];
      ld_mode         <= ad_in[DW-1:DW-2];
    end
    if (go_now || go_tc) begin
      cur      <= ld_cnt;
      act_len  <= ld_cnt;
      act_mode <= ld_mode;
    end else if (run && cnt_tick) begin
      cur <= tc ? act_len : cur - TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      stop_tc <= 1'b0;
      start_q <= 1'b0;
      done    <= 1'b0;
    end else begin
      if (rd_en && addr_q == 3'd0) done <= 1'b0;
      if (tc) begin
        done <= 1'b1;
        if (start_q) start_q <= 1'b0;
        else if (stop_tc || !act_mode[0]) begin
          run     <= 1'b0;
          stop_tc <= 1'b0;
        end
      end
      if (wr_cmd) begin
        case (op)
          2'b01: begin
            run     <= 1'b0;
            stop_tc <= 1'b0;
            start_q <= 1'b0;
          end
          2'b10: if (run) begin
            stop_tc <= 1'b1;
            start_q <= 1'b0;
          end
          2'b11: if (run && !tc) begin
            start_q <= 1'b1;
            stop_tc <= 1'b0;
          end else begin
            run     <= 1'b1;
            start_q <= 1'b0;
            stop_tc <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign tmr_out = !run ? 1'b1 :
                   act_mode[1] ? (cur != TW'(1)) : (cur > (act_len >> 1));

  assign pa_oe  = dir_q[0];
  assign pb_oe  = dir_q[1];
  assign pc_oe  = dir_q[2];
  assign pa_out = pa_q;
  assign pb_out = pb_q;
  assign pc_out = pc_q;
  assign ad_oe  = rd_en && rst_n;

  always_comb begin
    ad_out = '0;
    case (addr_q)
      3'd0: ad_out[DONE_BIT] = done;
      3'd1: ad_out = pa_oe ? pa_q : pa_in;
      3'd2: ad_out = pb_oe ? pb_q : pb_in;
      3'd3: ad_out[PCW-1:0] = pc_oe ? pc_q : pc_in;
      3'd4: ad_out = cur[DW-1:0];
      3'd5: ad_out = {act_mode, cur[TW-1:DW]};
      default: ;
    endcase
  end
endmodule

// File: rtl/io_timer_port_chk.sv
module io_timer_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_n,
  input logic       rd_n,
  input logic [7:0] ad_in,
  input logic       pa_oe,
  input logic       cnt_tick,
  input logic       tmr_out,
  input logic [2:0] addr_q,
  input logic       run,
  input logic       done
);
  assert_stop_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && addr_q == 3'd0 && ad_in[7:6] == 2'b01) |=> (tmr_out && !run));

  assert_dir_by_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pa_oe) |-> $past(!wr_n && addr_q == 3'd0));

  assert_no_tick_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n && !cnt_tick) |=> $stable(tmr_out));

  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && addr_q == 3'd0 && !cnt_tick) |=> !done);

  assert_start_needs_cmd_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(!wr_n && addr_q == 3'd0)) |=> !run);
endmodule

bind io_timer_port io_timer_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .ad_in(ad_in),
  .pa_oe(pa_oe), .cnt_tick(cnt_tick), .tmr_out(tmr_out),
  .addr_q(addr_q), .run(run), .done(done)
);

// File: tb/tb_io_timer_port.sv
module tb_io_timer_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1, cnt_tick = 1'b0;
  logic [7:0] ad_in = '0, pa_in = 8'hC3, pb_in = 8'h3C;
  logic [5:0] pc_in = 6'h2B;
  logic [7:0] ad_out, pa_out, pb_out;
  logic [5:0] pc_out;
  logic ad_oe, pa_oe, pb_oe, pc_oe, tmr_out;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #2 clk = ~clk;

  io_timer_port dut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .cnt_tick(cnt_tick), .tmr_out(tmr_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the expected read value for every read cycle
  always @(negedge clk) begin
    if (ad_oe) begin
      if (exp_q.size() == 0) check("R2 unexpected read", ad_out, 8'hxx);
      else check(req_q.pop_front(), ad_out, exp_q.pop_front());
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(); ale = 1'b1; ad_in = {5'b0, a};
    cyc(); ale = 1'b0; wr_n = 1'b0; ad_in = d;
    cyc(); wr_n = 1'b1;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    exp_q.push_back(exp); req_q.push_back(req);
    cyc(); ale = 1'b1; ad_in = {5'b0, a};
    cyc(); ale = 1'b0; rd_n = 1'b0;
    cyc(); rd_n = 1'b1;
  endtask

  task automatic tick();
    cyc(); cnt_tick = 1'b1;
    cyc(); cnt_tick = 1'b0;
  endtask

  task automatic chk_out(input logic exp, input string req);
    @(negedge clk);
    check(req, {7'b0, tmr_out}, {7'b0, exp});
  endtask

  task automatic start(input int n, input logic [1:0] mode, input logic [2:0] dir);
    wr(3'd4, n[7:0]);
    wr(3'd5, {mode, n[13:8]});
    wr(3'd0, {2'b11, 3'b0, dir});
  endtask

  function automatic logic sq_exp(input int n, input int k);
    int c = n - (k % n);
    return c > n / 2;
  endfunction

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    // reset state R13
    chk_out(1'b1, "R13 out after reset");
    check("R13 pa_oe after reset", {7'b0, pa_oe}, 8'h00);
    rd(3'd0, 8'h00, "R11 status after reset");
    rd(3'd1, 8'hC3, "R3 PA input after reset");
    rd(3'd6, 8'h00, "R1 unused address");

    // ports R3 R1
    wr(3'd1, 8'h5A); wr(3'd2, 8'hA5); wr(3'd3, 8'h15);
    rd(3'd2, 8'h3C, "R3 PB input");
    wr(3'd0, 8'h07);
    @(negedge clk);
    check("R3 pa_oe", {5'b0, pc_oe, pb_oe, pa_oe}, 8'h07);
    check("R3 pa_out", pa_out, 8'h5A);
    rd(3'd1, 8'h5A, "R3 PA output");
    rd(3'd2, 8'hA5, "R1 PB output");
    rd(3'd3, 8'h15, "R3 PC output");
    wr(3'd0, 8'h03);
    rd(3'd3, 8'h2B, "R3 PC input");

    // repeating square, even count R9 R8 R4 R11
    start(4, 2'b01, 3'b011);
    chk_out(1'b1, "R4 started out");
    for (int k = 1; k <= 9; k++) begin
      tick();
      chk_out(sq_exp(4, k), "R9 square n=4");
    end
    rd(3'd0, 8'h40, "R11 flag set");
    rd(3'd0, 8'h00, "R11 flag cleared");
    rd(3'd4, 8'h03, "R12 count low");
    rd(3'd5, 8'h40, "R12 count high");
    repeat (4) cyc();
    chk_out(sq_exp(4, 9), "R8 no tick hold");
    wr(3'd0, 8'h43);
    chk_out(1'b1, "R5 stop now");
    tick(); tick(); tick();
    chk_out(1'b1, "R5 stays stopped");
    rd(3'd0, 8'h00, "R5 no terminal count");

    // single square, odd count R9
    start(5, 2'b00, 3'b011);
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk_out(sq_exp(5, k), "R9 square odd n=5");
    end
    tick();
    chk_out(1'b1, "R9 single stops");
    tick(); tick();
    chk_out(1'b1, "R9 single stays high");
    rd(3'd0, 8'h40, "R11 single flag");

    // single pulse R10
    start(3, 2'b10, 3'b011);
    tick(); chk_out(1'b1, "R10 pulse step1");
    tick(); chk_out(1'b0, "R10 pulse low");
    tick(); chk_out(1'b1, "R10 pulse end");
    tick(); tick(); chk_out(1'b1, "R10 single pulse stopped");

    // stop at terminal count R6
    start(4, 2'b01, 3'b011);
    tick();
    wr(3'd0, 8'h83);
    tick(); chk_out(1'b0, "R6 still running");
    rd(3'd4, 8'h02, "R6 count advances");
    tick(); chk_out(1'b0, "R6 last step");
    tick(); chk_out(1'b1, "R6 stopped at tc");
    tick(); rd(3'd4, 8'h04, "R6 counter frozen");
    rd(3'd0, 8'h40, "R6 tc reported");

    // start while running R7
    start(4, 2'b01, 3'b011);
    tick();
    wr(3'd4, 8'd6); wr(3'd5, 8'hC0); wr(3'd0, 8'hC3);
    rd(3'd4, 8'h03, "R7 period untouched");
    rd(3'd5, 8'h40, "R7 mode untouched");
    tick(); tick(); chk_out(1'b0, "R7 old waveform");
    tick(); chk_out(1'b1, "R7 reload out");
    rd(3'd4, 8'h06, "R7 new count");
    rd(3'd5, 8'hC0, "R7 new mode");
    for (int k = 1; k <= 5; k++) tick();
    chk_out(1'b0, "R10 continuous pulse low");
    tick(); chk_out(1'b1, "R10 continuous reload");
    tick(); rd(3'd4, 8'h05, "R10 keeps counting");

    // reset mid-run R13
    cyc(); rst_n = 1'b0;
    cyc(); cyc(); rst_n = 1'b1;
    chk_out(1'b1, "R13 out after reset");
    tick(); tick();
    chk_out(1'b1, "R13 halted after reset");
    rd(3'd0, 8'h00, "R13 flag clear");
    rd(3'd1, 8'hC3, "R13 port input");

    repeat (3) cyc();
    check("R2 scoreboard drained", 8'(exp_q.size()), 8'h00);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule